// File: doc/BRIEF.md
# Iterative AES-128 Cipher and Inverse-Cipher Round Engine

This block runs AES-128 in either direction, one round on each clock edge. It is meant for chaining modes such as CBC, where each block depends on the previous result and blocks cannot be overlapped in a pipeline. The caller gives a 128-bit block, a direction flag and a one-cycle start strobe. A companion key scheduler supplies one 128-bit round key per cycle. After eleven clock edges the block reports the result together with a single-cycle done pulse.

Both directions share one multiplicative-inverse circuit per byte lane. The state register feeds the inverters directly, so no selector sits in front of them. During decryption the register holds the state after InvMixColumns, InvShiftRows and the inverse affine map. This retiming lets the next round start directly at the inverters. Behind the inverters, a per-lane demultiplexer passes the inverse to the active direction's linear path and drives the other path to zero. The two path outputs are then merged with a plain XOR instead of a multiplexer. The whitening key addition at start has its own adder, separate from the per-round key addition.

Top module: `aes_rnd_core`

## Requirements
- R1: Encryption: the key presented in the cycle of the start strobe is the whitening key K0. The keys K1 to K10 follow in the next ten cycles. The result equals AES-128 encryption of `block_i`. Byte 0 of the block is bits 127:120, and column c holds bytes 4c to 4c+3.
- R2: Decryption: the key presented with the start strobe is K10. The keys K9 down to K0 follow in the next ten cycles. The result equals AES-128 decryption of `block_i`.
- R3: `done_o` is high for exactly one cycle, after the eleventh rising edge counting the edge that samples the start strobe. It is low in every other cycle.
- R4: A start strobe that arrives while a block is in flight is ignored, together with its block and direction. The block in flight completes with its own result and on its own schedule.
- R5: Between done and the next accepted start, `result_o` holds its value and `done_o` stays low, whatever `block_i`, `rkey_i` and `decrypt_i` do.
- R6: While `rst_n` is low at a rising edge, `done_o` clears and `result_o` becomes zero. This includes an edge in the middle of a block, which abandons that block.
- R7: The direction is sampled with the start strobe. A change of `decrypt_i` while the block is in flight has no effect on its result.
- R8: A start strobe given in the cycle where `done_o` is high is accepted, so blocks can run back to back every eleven cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe; accepted only when idle |
| decrypt_i | input | 1 | 1 = decrypt, 0 = encrypt; sampled with the start strobe |
| block_i | input | 128 | Input block, byte 0 in bits 127:120 |
| rkey_i | input | 128 | Round key for the current cycle, supplied by the external scheduler |
| result_o | output | 128 | Result block; valid from the done cycle until the next start |
| done_o | output | 1 | One-cycle pulse marking a valid result |

## Verification
The bench builds the core with its default round count of ten, the only value that gives AES-128. This makes known published ciphertexts usable as expected values in both directions. The bench computes its own key expansion and S-box by brute-force field inversion, and feeds round keys in forward or reverse order. Four published key/plaintext pairs are each run through both directions. Further tests cover a stray start with a flipped direction in mid-block, back-to-back blocks, idle input churn, and a reset in mid-block.

// File: rtl/aes_rnd_pkg.sv
// Package: shared field arithmetic and byte permutations for the round engine.
// Assumes the standard AES field with reduction polynomial x^8+x^4+x^3+x+1
// and a 128-bit block whose byte 0 sits in bits 127:120, column-major order.
package aes_rnd_pkg;

    localparam int          BLK_W   = 128;
    localparam int          LANES   = BLK_W / 8;
    localparam int          COLS    = LANES / 4;
    localparam logic [7:0]  AFF_C   = 8'h63;   // forward affine constant
    localparam logic [7:0]  IAFF_C  = 8'h05;   // inverse affine constant

    // Multiply by x modulo the field polynomial.
    function automatic logic [7:0] gf_x2(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // General field multiply, shift-and-add.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_x2(sh);
        end
        return acc;
    endfunction

    // Multiplicative inverse as a^254; maps zero to zero.
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] sq;
        logic [7:0] acc;
        sq  = gf_mul(a, a);
        acc = sq;
        for (int i = 0; i < 6; i++) begin
            sq  = gf_mul(sq, sq);
            acc = gf_mul(acc, sq);
        end
        return acc;
    endfunction

    // Linear part of the forward affine map (constant added by the caller).
    function automatic logic [7:0] aff_lin(input logic [7:0] x);
        logic [7:0] b;
        for (int i = 0; i < 8; i++)
            b[i] = x[i] ^ x[(i+4)%8] ^ x[(i+5)%8] ^ x[(i+6)%8] ^ x[(i+7)%8];
        return b;
    endfunction

    // Linear part of the inverse affine map (constant added by the caller).
    function automatic logic [7:0] inv_aff_lin(input logic [7:0] x);
        logic [7:0] b;
        for (int i = 0; i < 8; i++)
            b[i] = x[(i+2)%8] ^ x[(i+5)%8] ^ x[(i+7)%8];
        return b;
    endfunction

    // Row r rotated left by r columns.
    function automatic logic [BLK_W-1:0] rows_fwd(input logic [BLK_W-1:0] s);
        logic [BLK_W-1:0] o;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                o[BLK_W-1-8*(4*c+r) -: 8] = s[BLK_W-1-8*(4*((c+r)%4)+r) -: 8];
        return o;
    endfunction

    // Row r rotated right by r columns.
    function automatic logic [BLK_W-1:0] rows_inv(input logic [BLK_W-1:0] s);
        logic [BLK_W-1:0] o;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                o[BLK_W-1-8*(4*c+r) -: 8] = s[BLK_W-1-8*(4*((c-r+4)%4)+r) -: 8];
        return o;
    endfunction

endpackage

// File: rtl/aes_sub_lane.sv
// Module: one byte lane of the shared substitution stage.
// Computes the field inverse of the registered byte with no selector in front,
// then demultiplexes it: the inactive direction's output is forced to zero.
// Assumes dec_i is stable for the whole block (latched by the controller).
module aes_sub_lane
    import aes_rnd_pkg::*;
(
    input  logic [7:0] byte_i,
    input  logic       dec_i,
    output logic [7:0] enc_o,
    output logic [7:0] dec_o
);

    logic [7:0] inv_b;

    // Shared inverter followed by the 1-to-2 demultiplexer.
    always_comb begin
        inv_b = gf_inv(byte_i);
        enc_o = inv_b & {8{~dec_i}};
        dec_o = inv_b & {8{dec_i}};
    end

endmodule

// File: rtl/aes_col_mix.sv
// Module: one column of MixColumns (INVERSE=0) or InvMixColumns (INVERSE=1).
// Each output byte is one 4-input 8-bit XOR adder over scaled input bytes.
// bypass_i passes the column through unchanged, for the last round.
module aes_col_mix
    import aes_rnd_pkg::*;
#(
    parameter int INVERSE = 0
) (
    input  logic [31:0] col_i,
    input  logic        bypass_i,
    output logic [31:0] col_o
);

    logic [7:0] b0, b1, b2, b3;
    logic [31:0] mixed;

    assign b0 = col_i[31:24];
    assign b1 = col_i[23:16];
    assign b2 = col_i[15:8];
    assign b3 = col_i[7:0];

    generate
        if (INVERSE == 0) begin : g_fwd
            // Forward coefficients 02 03 01 01, rotated per row.
            always_comb begin
                mixed[31:24] = gf_x2(b0) ^ (gf_x2(b1) ^ b1) ^ b2 ^ b3;
                mixed[23:16] = b0 ^ gf_x2(b1) ^ (gf_x2(b2) ^ b2) ^ b3;
                mixed[15:8]  = b0 ^ b1 ^ gf_x2(b2) ^ (gf_x2(b3) ^ b3);
                mixed[7:0]   = (gf_x2(b0) ^ b0) ^ b1 ^ b2 ^ gf_x2(b3);
            end
        end else begin : g_inv
            // Inverse coefficients 0e 0b 0d 09, rotated per row.
            always_comb begin
                mixed[31:24] = gf_mul(b0, 8'h0e) ^ gf_mul(b1, 8'h0b) ^ gf_mul(b2, 8'h0d) ^ gf_mul(b3, 8'h09);
                mixed[23:16] = gf_mul(b0, 8'h09) ^ gf_mul(b1, 8'h0e) ^ gf_mul(b2, 8'h0b) ^ gf_mul(b3, 8'h0d);
                mixed[15:8]  = gf_mul(b0, 8'h0d) ^ gf_mul(b1, 8'h09) ^ gf_mul(b2, 8'h0e) ^ gf_mul(b3, 8'h0b);
                mixed[7:0]   = gf_mul(b0, 8'h0b) ^ gf_mul(b1, 8'h0d) ^ gf_mul(b2, 8'h09) ^ gf_mul(b3, 8'h0e);
            end
        end
    endgenerate

    // Final-round bypass.
    assign col_o = bypass_i ? col_i : mixed;

endmodule

// File: rtl/aes_rnd_ctrl.sv
// Module: round sequencer. Accepts a start only when idle, latches the
// direction, counts rounds 1..NR and raises a one-cycle done after round NR.
// Assumes synchronous active-low reset; start during a block is dropped.
module aes_rnd_ctrl #(
    parameter int NR = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic decrypt_i,
    output logic load_o,
    output logic busy_o,
    output logic dir_o,
    output logic last_o,
    output logic done_o
);

    localparam int RW = $clog2(NR + 1);

    logic          busy_q;
    logic          dir_q;
    logic          done_q;
    logic [RW-1:0] rnd_q;

    assign load_o = start_i && !busy_q;
    assign last_o = busy_q && (rnd_q == RW'(NR));
    assign busy_o = busy_q;
    assign dir_o  = dir_q;
    assign done_o = done_q;

    // Round counter, direction latch and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            dir_q  <= 1'b0;
            done_q <= 1'b0;
            rnd_q  <= '0;
        end else if (load_o) begin
            busy_q <= 1'b1;
            dir_q  <= decrypt_i;
            done_q <= 1'b0;
            rnd_q  <= RW'(1);
        end else if (busy_q) begin
            if (last_o) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                rnd_q  <= '0;
            end else begin
                done_q <= 1'b0;
                rnd_q  <= rnd_q + RW'(1);
            end
        end else begin
            done_q <= 1'b0;
        end
    end

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R3
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(last_o));

    // R4
    busy_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !last_o) |=> (busy_q && rnd_q == $past(rnd_q) + RW'(1)));

    // R7
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !last_o) |=> $stable(dir_q));

endmodule

// File: rtl/aes_rnd_core.sv
// Module: top of the round-iterative AES-128 cipher/inverse-cipher.
// Encryption register holds the plain state; decryption register holds the
// state after InvMixColumns, InvShiftRows and the inverse affine, so both
// directions start each round directly at the shared inverters.
// Assumes round keys arrive one per cycle: with start, then NR more.
module aes_rnd_core
    import aes_rnd_pkg::*;
#(
    parameter int NR = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             decrypt_i,
    input  logic [127:0]     block_i,
    input  logic [127:0]     rkey_i,
    output logic [127:0]     result_o,
    output logic             done_o
);

    logic             load, busy, dir, last;
    logic [BLK_W-1:0] state_q;
    logic [BLK_W-1:0] sub_enc, sub_dec;
    logic [BLK_W-1:0] enc_aff, enc_sr, enc_mix, enc_out;
    logic [BLK_W-1:0] dec_key, dec_mix, dec_sr, dec_out;
    logic [BLK_W-1:0] next_state, init_white, init_isr, init_val;

    aes_rnd_ctrl #(.NR(NR)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .decrypt_i (decrypt_i),
        .load_o    (load),
        .busy_o    (busy),
        .dir_o     (dir),
        .last_o    (last),
        .done_o    (done_o)
    );

    // Separate whitening adder, followed for decryption by the retimed
    // InvShiftRows and inverse affine.
    assign init_white = block_i ^ rkey_i;
    assign init_isr   = rows_inv(init_white);

    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_lane
            localparam int HI = BLK_W - 1 - 8 * gi;

            aes_sub_lane u_lane (
                .byte_i (state_q[HI -: 8]),
                .dec_i  (dir),
                .enc_o  (sub_enc[HI -: 8]),
                .dec_o  (sub_dec[HI -: 8])
            );

            // Forward affine; constant only while encrypting.
            assign enc_aff[HI -: 8] = aff_lin(sub_enc[HI -: 8]) ^ (dir ? 8'h00 : AFF_C);

            // Retimed inverse affine for the next round; skipped in the last.
            assign dec_out[HI -: 8] = last ? dec_mix[HI -: 8]
                                           : (inv_aff_lin(dec_sr[HI -: 8]) ^ (dir ? IAFF_C : 8'h00));

            // Initial value for the state register.
            assign init_val[HI -: 8] = decrypt_i ? (inv_aff_lin(init_isr[HI -: 8]) ^ IAFF_C)
                                                 : init_white[HI -: 8];
        end

        for (gi = 0; gi < COLS; gi++) begin : g_col
            localparam int CH = BLK_W - 1 - 32 * gi;

            aes_col_mix #(.INVERSE(0)) u_mix_e (
                .col_i    (enc_sr[CH -: 32]),
                .bypass_i (last),
                .col_o    (enc_mix[CH -: 32])
            );

            aes_col_mix #(.INVERSE(1)) u_mix_d (
                .col_i    (dec_key[CH -: 32]),
                .bypass_i (last),
                .col_o    (dec_mix[CH -: 32])
            );
        end
    endgenerate

    // Forward path: ShiftRows after the affine, key added after mixing.
    assign enc_sr  = rows_fwd(enc_aff);
    assign enc_out = enc_mix ^ (rkey_i & {BLK_W{~dir}});

    // Inverse path: key added before InvMixColumns, then InvShiftRows.
    assign dec_key = sub_dec ^ (rkey_i & {BLK_W{dir}});
    assign dec_sr  = rows_inv(dec_mix);

    // Inactive path is all zero, so a plain XOR merges the two.
    assign next_state = enc_out ^ dec_out;

    // State register: load on accepted start, advance while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else if (load)
            state_q <= init_val;
        else if (busy)
            state_q <= next_state;
    end

    assign result_o = state_q;

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_i) |=> $stable(state_q));

endmodule

// File: tb/aes_rnd_core_tb.sv
module aes_rnd_core_tb;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start_i;
    logic         decrypt_i;
    logic [127:0] block_i;
    logic [127:0] rkey_i;
    logic [127:0] result_o;
    logic         done_o;

    int n_tests = 0;
    int n_fail  = 0;

    logic [127:0] rk_tb [11];

    localparam int NV = 4;
    localparam logic [127:0] TV_KEY [NV] = '{
        128'h000102030405060708090a0b0c0d0e0f,
        128'h2b7e151628aed2a6abf7158809cf4f3c,
        128'h2b7e151628aed2a6abf7158809cf4f3c,
        128'h2b7e151628aed2a6abf7158809cf4f3c };
    localparam logic [127:0] TV_PT [NV] = '{
        128'h00112233445566778899aabbccddeeff,
        128'h3243f6a8885a308d313198a2e0370734,
        128'h6bc1bee22e409f96e93d7e117393172a,
        128'hae2d8a571e03ac9c9eb76fac45af8e51 };
    localparam logic [127:0] TV_CT [NV] = '{
        128'h69c4e0d86a7b0430d8cdb78070b4c55a,
        128'h3925841d02dc09fbdc118597196a0b32,
        128'h3ad77bb40d7a3660a89ecaf32466ef97,
        128'hf5d3d58503b9699de785895a96fdbaaf };

    always #4 clk = ~clk;

    aes_rnd_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .decrypt_i (decrypt_i),
        .block_i   (block_i),
        .rkey_i    (rkey_i),
        .result_o  (result_o),
        .done_o    (done_o)
    );

    function automatic logic [7:0] tb_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
        end
        return p;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    function automatic logic [7:0] tb_sbox(input logic [7:0] a);
        logic [7:0] inv = 8'h00;
        for (int y = 1; y < 256; y++)
            if (tb_mul(a, 8'(y)) == 8'h01) inv = 8'(y);
        return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
    endfunction

    task automatic expand(input logic [127:0] key);
        logic [31:0] w [44];
        logic [31:0] t;
        logic [7:0]  rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            t = w[i-1];
            if (i % 4 == 0) begin
                t = {t[23:0], t[31:24]};
                t = {tb_sbox(t[31:24]), tb_sbox(t[23:16]), tb_sbox(t[15:8]), tb_sbox(t[7:0])};
                t ^= {rc, 24'h0};
                rc = tb_mul(rc, 8'h02);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int r = 0; r < 11; r++) rk_tb[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    endtask

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; drives start now, returns at the negedge where done is expected.
    task automatic run_block(input logic [127:0] key, input logic [127:0] blk, input bit dec,
                             input int glitch_at, output logic [127:0] res);
        bit quiet = 1'b1;
        expand(key);
        start_i   = 1'b1;
        decrypt_i = dec;
        block_i   = blk;
        rkey_i    = dec ? rk_tb[10] : rk_tb[0];
        for (int j = 1; j <= 10; j++) begin
            @(negedge clk);
            if (done_o) quiet = 1'b0;
            start_i   = (j == glitch_at);
            decrypt_i = (j == glitch_at) ? ~dec : dec;
            block_i   = (j == glitch_at) ? ~blk : blk;
            rkey_i    = dec ? rk_tb[10-j] : rk_tb[j];
        end
        @(negedge clk);
        start_i = 1'b0;
        check(quiet, "R3 done low during rounds", {127'h0, ~quiet}, 128'h0);
        check(done_o, "R3 done after eleventh edge", {127'h0, done_o}, 128'h1);
        res = result_o;
    endtask

    initial begin
        logic [127:0] res;
        logic [127:0] held;
        rst_n = 1'b0; start_i = 1'b0; decrypt_i = 1'b0; block_i = '1; rkey_i = '1;
        repeat (3) @(negedge clk);
        // R6 reset state
        check(done_o == 1'b0, "R6 done in reset", {127'h0, done_o}, 128'h0);
        check(result_o == '0, "R6 result in reset", result_o, 128'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: each entry run in both directions.
        for (int i = 0; i < NV; i++) begin
            run_block(TV_KEY[i], TV_PT[i], 1'b0, 0, res);
            check(res == TV_CT[i], "R1 encrypt", res, TV_CT[i]);
            @(negedge clk);
            check(done_o == 1'b0, "R3 done one cycle", {127'h0, done_o}, 128'h0);
            run_block(TV_KEY[i], TV_CT[i], 1'b1, 0, res);
            check(res == TV_PT[i], "R2 decrypt", res, TV_PT[i]);
            @(negedge clk);
        end

        // R4 and R7: stray start with flipped direction in mid-block.
        run_block(TV_KEY[1], TV_PT[1], 1'b0, 4, res);
        check(res == TV_CT[1], "R4 R7 stray start ignored (enc)", res, TV_CT[1]);
        @(negedge clk);
        run_block(TV_KEY[2], TV_CT[2], 1'b1, 7, res);
        check(res == TV_PT[2], "R4 R7 stray start ignored (dec)", res, TV_PT[2]);

        // R5: idle churn leaves result and done alone.
        held = res;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            block_i = {4{32'(k) * 32'h9e3779b9}};
            rkey_i = ~block_i;
            decrypt_i = k[0];
            check(result_o == held && !done_o, "R5 idle hold", result_o, held);
        end

        // R8: back-to-back blocks, next start in the done cycle.
        @(negedge clk);
        run_block(TV_KEY[0], TV_PT[0], 1'b0, 0, res);
        check(res == TV_CT[0], "R8 first of pair", res, TV_CT[0]);
        run_block(TV_KEY[3], TV_CT[3], 1'b1, 0, res);
        check(res == TV_PT[3], "R8 second of pair", res, TV_PT[3]);

        // R6: reset in mid-block.
        @(negedge clk);
        expand(TV_KEY[1]);
        start_i = 1'b1; decrypt_i = 1'b0; block_i = TV_PT[1]; rkey_i = rk_tb[0];
        repeat (3) begin
            @(negedge clk);
            start_i = 1'b0;
        end
        rst_n = 1'b0;
        @(negedge clk);
        check(result_o == '0 && !done_o, "R6 mid-block reset", result_o, 128'h0);
        rst_n = 1'b1;
        repeat (12) begin
            @(negedge clk);
            check(!done_o, "R6 no done after abandoned block", {127'h0, done_o}, 128'h0);
        end
        run_block(TV_KEY[1], TV_PT[1], 1'b0, 0, res);
        check(res == TV_CT[1], "R6 R1 run after reset", res, TV_CT[1]);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule